// File: doc/BRIEF.md
# Multiplexed Local Bus Master

This block is the initiating end of a narrow board-level bus that shares one 16-bit path between addresses and data. A host issues a single 32-bit read or write through a simple request port. The master then runs one transfer on the bus and returns a one-cycle completion pulse. For a read, the 32-bit result comes back with that pulse.

Each transfer has a fixed shape. It opens with one address clock, in which the active-low strobe is low and the direction line is set. Two data phases follow. Each data phase moves 16 bits, lower half first, and advances only when the target pulls its active-low ready line low. The active-low last-phase line is held low for the whole second phase.

The bus is split into output, output-enable and input vectors, so the pad or tristate logic can sit at the chip edge. A wait counter aborts a data phase that never sees ready and reports an error to the host.

Top module: `lbus_master`

## Requirements
- R1: `req_ready_o` is high only while the master is idle, and a request is taken only on a clock edge where both `req_valid_i` and `req_ready_o` are high. A taken request pulls `ads_no` low for exactly the following clock.
- R2: While `ads_no` is low, `wr_o` is 1 for a write and 0 for a read.
- R3: While `ads_no` is low, `lad_o` carries the request address and `lad_oe_o` is high.
- R4: An access has two data phases after the address clock. A data phase ends only on a clock edge where `ready_ni` is low, and it holds for any number of wait cycles below the limit.
- R5: `blast_no` is high during the address clock and the first data phase. It is low throughout the second data phase, and high when idle.
- R6: The lower 16 bits move in the first data phase and the upper 16 bits in the second. A write drives `req_wdata_i[15:0]`, then `[31:16]`, on `lad_o`. A read captures `lad_i` as the lower half, then as the upper half.
- R7: During a write, `lad_oe_o` stays high through both data phases. During a read, `lad_oe_o` is low in both data phases.
- R8: `done_o` pulses high for one cycle, in the cycle after the edge that ends the second data phase. For a read, `rd_data_o` then equals {upper half, lower half}.
- R9: If `ready_ni` stays high for WAIT_LIMIT consecutive edges in a data phase, the master returns to idle. `err_o` then pulses for one cycle, and no `done_o` pulse follows.
- R10: After reset, `ads_no` and `blast_no` are high, `lad_oe_o`, `done_o` and `err_o` are low, and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Master idle, request can be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Register address |
| req_wdata_i | input | 32 | Write data |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle wait-limit error pulse |
| rd_data_o | output | 32 | Assembled read data |
| ads_no | output | 1 | Address strobe, active low |
| wr_o | output | 1 | Direction, 1 = write |
| blast_no | output | 1 | Last data phase, active low |
| ready_ni | input | 1 | Target ready, active low |
| lad_o | output | 16 | Shared bus, driven value |
| lad_oe_o | output | 1 | Shared bus output enable |
| lad_i | input | 16 | Shared bus, received value |

## Verification
The bench builds the master with WAIT_LIMIT set to 4. At that size the bench can cover every pair of wait counts (0 to 3) for the two data phases, for both reads and writes. It also forces a timeout in each of the two phases. The sweep includes the edge where the counter sits one short of the limit, and it covers host requests held high through a busy access.

// File: rtl/lbm_pkg.sv
package lbm_pkg;
  localparam int unsigned BUS_W  = 16;
  localparam int unsigned WORD_W = 2 * BUS_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_DLO   = 2'd2,
    ST_DHI   = 2'd3
  } lbm_state_e;
endpackage

// File: rtl/lbm_wait_timer.sv
module lbm_wait_timer #(
  parameter int unsigned WAIT_LIMIT = 64,
  localparam int unsigned CNT_W = $clog2(WAIT_LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic ready_i,
  output logic expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_lim;

  assign at_lim   = (cnt_q == CNT_W'(WAIT_LIMIT - 1));
  assign expire_o = run_i && !ready_i && at_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (!run_i || ready_i || at_lim) cnt_q <= '0;
    else                                 cnt_q <= cnt_q + 1'b1;
  end

  // R9
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(WAIT_LIMIT));
  // R9
  idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(run_i) |-> cnt_q == '0);
endmodule

// File: rtl/lbm_rd_collect.sv
module lbm_rd_collect #(
  parameter int unsigned BUS_W = 16,
  localparam int unsigned WORD_W = 2 * BUS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_lo_i,
  input  logic              take_hi_i,
  input  logic              abort_i,
  input  logic [BUS_W-1:0]  lad_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              done_o,
  output logic              err_o
);
  logic [BUS_W-1:0] lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q      <= '0;
      rd_data_o <= '0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      done_o <= take_hi_i;
      err_o  <= abort_i;
      if (take_lo_i) lo_q <= lad_i;
      if (take_hi_i) rd_data_o <= {lad_i, lo_q};
    end
  end

  // R9
  done_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  // R8
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/lbus_master.sv
module lbus_master
  import lbm_pkg::*;
#(
  parameter int unsigned WAIT_LIMIT = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [BUS_W-1:0]  req_addr_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  output logic              done_o,
  output logic              err_o,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              ads_no,
  output logic              wr_o,
  output logic              blast_no,
  input  logic              ready_ni,
  output logic [BUS_W-1:0]  lad_o,
  output logic              lad_oe_o,
  input  logic [BUS_W-1:0]  lad_i
);
  lbm_state_e        state_q, state_d;
  logic              write_q;
  logic [BUS_W-1:0]  addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic              in_data, phase_ok, expire;

  assign in_data     = (state_q == ST_DLO) || (state_q == ST_DHI);
  assign phase_ok    = in_data && !ready_ni;
  assign req_ready_o = (state_q == ST_IDLE);

  lbm_wait_timer #(.WAIT_LIMIT(WAIT_LIMIT)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (in_data),
    .ready_i  (!ready_ni),
    .expire_o (expire)
  );

  lbm_rd_collect #(.BUS_W(BUS_W)) i_collect (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_lo_i (state_q == ST_DLO && phase_ok),
    .take_hi_i (state_q == ST_DHI && phase_ok),
    .abort_i   (expire),
    .lad_i     (lad_i),
    .rd_data_o (rd_data_o),
    .done_o    (done_o),
    .err_o     (err_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_DLO;
      ST_DLO:  if (phase_ok) state_d = ST_DHI; else if (expire) state_d = ST_IDLE;
      ST_DHI:  if (phase_ok || expire) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (req_ready_o && req_valid_i) begin
        write_q <= req_write_i;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
    end
  end

  // bus drive: address, then low half, then high half
  always_comb begin
    ads_no   = (state_q != ST_ADDR);
    blast_no = (state_q != ST_DHI);
    wr_o     = (state_q != ST_IDLE) && write_q;
    lad_oe_o = (state_q == ST_ADDR) || (in_data && write_q);
    unique case (state_q)
      ST_ADDR: lad_o = addr_q;
      ST_DLO:  lad_o = wdata_q[BUS_W-1:0];
      ST_DHI:  lad_o = wdata_q[WORD_W-1:BUS_W];
      default: lad_o = '0;
    endcase
  end

  // R1
  ads_one_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ads_no |=> ads_no);
  // R1
  ads_after_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ads_no) |-> $past(req_valid_i && req_ready_o));
  // R2
  dir_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ads_no |-> wr_o == $past(req_write_i));
  // R3
  addr_on_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ads_no |-> (lad_oe_o && lad_o == $past(req_addr_i)));
  // R5
  blast_not_ads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blast_no |-> ads_no);
  // R7
  read_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ads_no && !wr_o) |=> !lad_oe_o);
  // R8
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(!blast_no && !ready_ni));
endmodule

// File: tb/test_lbus_master.sv
module test_lbus_master;
  localparam int unsigned LIM = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, done, err, ads_n, wr, blast_n, lad_oe;
  logic [31:0] rd_data;
  logic        ready_n = 1'b1;
  logic [15:0] lad_out, lad_in = '0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lbus_master #(.WAIT_LIMIT(LIM)) i_lbus_master (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .done_o(done), .err_o(err), .rd_data_o(rd_data), .ads_no(ads_n), .wr_o(wr),
    .blast_no(blast_n), .ready_ni(ready_n), .lad_o(lad_out), .lad_oe_o(lad_oe),
    .lad_i(lad_in));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one data phase: w waits then ready; w >= LIM means never ready
  task automatic phase(input bit hi, input bit wr_en, input int w,
                       input logic [15:0] wval, input logic [15:0] rval,
                       output bit timed_out);
    timed_out = 0;
    for (int k = 0; k < w && k < LIM; k++) begin
      ready_n = 1'b1;
      chk("R5 blast level", blast_n, !hi);
      chk("R7 bus enable", lad_oe, wr_en);
      chk("R1 busy not ready", {req_ready, ads_n}, 2'b01);
      @(posedge clk); #1;
    end
    if (w >= LIM) begin timed_out = 1; return; end
    ready_n = 1'b0;
    lad_in  = rval;
    chk("R5 blast level", blast_n, !hi);
    chk("R7 bus enable", lad_oe, wr_en);
    if (wr_en) chk("R6 write half", lad_out, wval);
    @(posedge clk); #1;
    ready_n = 1'b1;
  endtask

  task automatic access(input bit wr_en, input logic [15:0] a, input logic [31:0] d,
                        input int w0, input int w1, input bit hold);
    bit to;
    @(negedge clk);
    chk("R1 idle ready", req_ready, 1'b1);
    req_valid = 1'b1; req_write = wr_en; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    if (hold) begin req_addr = ~a; req_write = !wr_en; end else req_valid = 1'b0;
    chk("R1 strobe low", ads_n, 1'b0);
    chk("R2 direction", wr, wr_en);
    chk("R3 address", {lad_oe, lad_out}, {1'b1, a});
    chk("R5 blast high in addr", blast_n, 1'b1);
    @(posedge clk); #1;
    chk("R1 strobe one clock", ads_n, 1'b1);
    phase(1'b0, wr_en, w0, d[15:0], d[15:0], to);
    if (to) begin
      chk("R9 err pulse", {err, done, req_ready}, 3'b101);
      req_valid = 1'b0;
      @(posedge clk); #1;
      chk("R9 err one cycle", err, 1'b0);
      return;
    end
    chk("R4 second phase", blast_n, 1'b0);
    phase(1'b1, wr_en, w1, d[31:16], d[31:16], to);
    req_valid = 1'b0;
    if (to) begin
      chk("R9 err pulse", {err, done, req_ready}, 3'b101);
      @(posedge clk); #1;
      chk("R9 err one cycle", {err, done}, 2'b00);
      return;
    end
    chk("R8 done", {done, err}, 2'b10);
    chk("R4 back idle", {req_ready, blast_n, ads_n}, 3'b111);
    if (!wr_en) chk("R8 R6 read data", rd_data, d);
    @(posedge clk); #1;
    chk("R8 done one cycle", done, 1'b0);
    chk("R1 no extra strobe", ads_n, 1'b1);
  endtask

  initial begin
    #1;
    chk("R10 reset outs", {ads_n, blast_n, lad_oe, done, err, req_ready}, 6'b110001);
    #11 rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R10 after release", {ads_n, blast_n, lad_oe, req_ready}, 4'b1101);
    for (int m = 0; m < 2; m++)
      for (int w0 = 0; w0 < LIM; w0++)
        for (int w1 = 0; w1 < LIM; w1++) begin
          logic [15:0] a;
          a = 16'(16'h1000 + m * 16 + w0 * 4 + w1);
          access(m[0], a, {a ^ 16'h5A3C, ~a}, w0, w1, (w0 + w1) % 3 == 0);
        end
    access(1'b1, 16'h0F0F, 32'h1234_ABCD, LIM, 0, 1'b0);   // R9 first phase
    access(1'b0, 16'h00F1, 32'hCAFE_0001, 1, LIM, 1'b0);   // R9 second phase
    access(1'b0, 16'hFFFF, 32'hFFFF_0000, 0, 0, 1'b0);
    access(1'b1, 16'h0000, 32'h8000_0001, LIM - 1, LIM - 1, 1'b0);
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=finish");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule